// File: doc/BRIEF.md
# Chained Indirect Pointer-Pair Resolver

This block follows an indirect reference that is stored as a pair of 36-bit words in memory. It is given a two-part address made of a segment number and a word number. It reads the pair at that address and checks the mode code in the first word.

The next step depends on that mode code:

- **Pointer code:** the segment and word fields of the first word form a new address. The second word can add an index register to the word part. The second word can also ask for another indirection step, and the block then repeats the walk at the new address.
- **Unresolved-link code:** the block stops with a fault. The fault reports the pair's segment and word fields, so a handler can find the symbolic reference. Once the handler rewrites the pair as an ordinary pointer, the same reference resolves with just two memory reads.
- **Any other code:** the block raises a malformed-pair fault.
- **Endless chain:** a chain of indirections longer than a configured bound raises a loop fault.

A memory port carries one-cycle read requests and a valid-qualified data return. An index port reads one index register combinationally. The result comes back either as a one-cycle completion strobe or as a fault that stays held until it is acknowledged.

Top module: `irp_resolver`

## Requirements
- R1: Every pair costs exactly two reads, each a one-cycle `mem_rd` pulse. The reads go to the same segment: first the even word (word number with bit 0 cleared), then the odd word (bit 0 set). The odd read is issued only after the even data has returned.
- R2: First-word layout: bits [3:0] hold the mode, bits [21:4] the word number, bits [35:22] the segment number. Mode 0x3 is the pointer code, and its segment and word fields form the new address.
- R3: Second-word layout: bit 4 enables indexing and bits [2:0] select the index register. When indexing is enabled, the new word number is the pointer's word plus the register value, modulo 2^18. When it is disabled, the pointer's word is used unchanged.
- R4: Bit 5 of the second word requests another indirection, which reads a new pair at the formed address. Without it, `done` pulses for exactly one cycle and `res_seg`/`res_word` carry the formed address.
- R5: Mode 0xB is the unresolved-link code. It raises `fault` with `fault_code` 1, and `fault_seg`/`fault_word` carry the first word's raw segment and word fields. This fault is raised only after both reads complete, and `done` is not pulsed.
- R6: Any mode other than 0x3 or 0xB raises `fault_code` 3. The fault address is the pair's own address (segment, and word with bit 0 cleared).
- R7: A further-indirection request on the MAX_CHAIN-th pair of one resolution (default 16) raises `fault_code` 2. The fault address is the address that pair formed.
- R8: `fault` and its code and address stay constant until `fault_ack`. While the fault is held, no read is issued. `fault` is low in the cycle after the acknowledge edge.
- R9: `start` is accepted only while the block is neither busy nor holding a fault. Otherwise it is ignored, and the outcome of the resolution in progress is unchanged.
- R10: When memory returns data in the cycle after each read, the outcome (`done` or `fault`) is visible exactly 5·N clock edges after the start edge, where N is the number of pairs read. Before that, `done` and `fault` stay low.
- R11: After reset, `busy`, `mem_rd`, `done` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a resolution (accepted when idle) |
| start_seg | input | 14 | Segment of the first pair |
| start_word | input | 18 | Word number of the first pair |
| busy | output | 1 | Resolution in progress |
| mem_rd | output | 1 | One-cycle read request |
| mem_seg | output | 14 | Read segment |
| mem_word | output | 18 | Read word number |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 36 | Read data |
| idx_sel | output | 3 | Index register selected by the second word |
| idx_val | input | 18 | Value of the selected index register |
| done | output | 1 | One-cycle completion strobe |
| res_seg | output | 14 | Resolved segment |
| res_word | output | 18 | Resolved word number |
| fault | output | 1 | Fault held until acknowledged |
| fault_code | output | 2 | 1 link, 2 loop, 3 bad mode |
| fault_seg | output | 14 | Fault segment field |
| fault_word | output | 18 | Fault word field |
| fault_ack | input | 1 | Clear a held fault |

## Verification
Each pair takes five clock edges: even read, even data, odd read, odd data, and evaluation. So with the bench's one-cycle memory, the outcome of an N-pair resolution is due exactly 5·N edges after the edge that accepts `start`. The bench's behavioural model walks the same pairs in its memory image to find N, the outcome and the addresses. It then samples at every falling edge, requires `done` and `fault` to stay low until edge 5·N, and checks the result there. A completion is also checked to be gone one cycle later. A fault is checked for holding across an extra cycle and a rejected `start`, and then for clearing one cycle after the acknowledge.

// File: rtl/irp_pkg.sv
// Package: shared codes and state type for the pointer-pair resolver.
// Assumes a pair's first word carries mode in its low MODE_W bits.
package irp_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_SEGIND   = 4'h3;
    localparam logic [MODE_W-1:0] MODE_LINKTRAP = 4'hB;
    localparam int X_EN_BIT    = 4;
    localparam int X_CHAIN_BIT = 5;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_LINK = 2'd1,
        FLT_LOOP = 2'd2,
        FLT_MODE = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_EVEN,
        ST_WT_EVEN,
        ST_RD_ODD,
        ST_WT_ODD,
        ST_EVAL,
        ST_FAULT
    } state_e;
endpackage

// File: rtl/irp_pair_decode.sv
// Module: splits a fetched word pair into pointer fields and control bits.
// Assumes IDX_SEL_W <= X_EN_BIT so the index number sits below the enable bit.
module irp_pair_decode
    import irp_pkg::*;
#(
    parameter int SEG_W     = 14,
    parameter int WORD_W    = 18,
    parameter int IDX_SEL_W = 3,
    localparam int DATA_W   = SEG_W + WORD_W + MODE_W
) (
    input  logic [DATA_W-1:0]    first_w,
    input  logic [DATA_W-1:0]    second_w,
    output logic [SEG_W-1:0]     ptr_seg,
    output logic [WORD_W-1:0]    ptr_word,
    output logic                 is_ptr,
    output logic                 is_trap,
    output logic                 idx_en,
    output logic [IDX_SEL_W-1:0] idx_num,
    output logic                 chain
);
    logic [MODE_W-1:0] mode;
    logic              unused_bits;

    // Field extraction from the first word.
    always_comb begin
        mode     = first_w[MODE_W-1:0];
        ptr_word = first_w[MODE_W +: WORD_W];
        ptr_seg  = first_w[DATA_W-1 -: SEG_W];
        is_ptr   = (mode == MODE_SEGIND);
        is_trap  = (mode == MODE_LINKTRAP);
    end

    // Control bits from the second word.
    always_comb begin
        idx_en  = second_w[X_EN_BIT];
        chain   = second_w[X_CHAIN_BIT];
        idx_num = second_w[IDX_SEL_W-1:0];
    end

    assign unused_bits = ^{second_w[DATA_W-1:X_CHAIN_BIT+1], second_w[X_EN_BIT-1:IDX_SEL_W]};
endmodule

// File: rtl/irp_addr_calc.sv
// Module: forms the next word number, optionally adding an index register.
// Assumes wrap-around modulo 2^WORD_W.
module irp_addr_calc #(
    parameter int WORD_W = 18
) (
    input  logic [WORD_W-1:0] ptr_word,
    input  logic              idx_en,
    input  logic [WORD_W-1:0] idx_val,
    output logic [WORD_W-1:0] next_word
);
    // Indexed sum, truncated to the word-number width.
    always_comb begin
        next_word = ptr_word + (idx_en ? idx_val : '0);
    end
endmodule

// File: rtl/irp_ctrl.sv
// Module: sequencer that reads pairs, evaluates them and reports the outcome.
// Assumes memory data returns no earlier than the cycle after a read pulse.
module irp_ctrl
    import irp_pkg::*;
#(
    parameter int SEG_W     = 14,
    parameter int WORD_W    = 18,
    parameter int MAX_CHAIN = 16,
    localparam int DATA_W   = SEG_W + WORD_W + MODE_W,
    localparam int CNT_W    = $clog2(MAX_CHAIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEG_W-1:0]  start_seg,
    input  logic [WORD_W-1:0] start_word,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              fault_ack,
    input  logic              is_ptr,
    input  logic              is_trap,
    input  logic              chain,
    input  logic [SEG_W-1:0]  ptr_seg,
    input  logic [WORD_W-1:0] ptr_word,
    input  logic [WORD_W-1:0] next_word,
    output logic [DATA_W-1:0] word0_q,
    output logic [DATA_W-1:0] word1_q,
    output logic              busy,
    output logic              mem_rd,
    output logic [SEG_W-1:0]  mem_seg,
    output logic [WORD_W-1:0] mem_word,
    output logic              done,
    output logic [SEG_W-1:0]  res_seg,
    output logic [WORD_W-1:0] res_word,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic [SEG_W-1:0]  fault_seg,
    output logic [WORD_W-1:0] fault_word
);
    state_e            st;
    fault_e            flt_q;
    logic [SEG_W-1:0]  cur_seg;
    logic [WORD_W-1:0] cur_word;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] pair_base;

    // Pair base address with the low word bit cleared.
    assign pair_base  = {cur_word[WORD_W-1:1], 1'b0};

    // Read port and status decoding from the state.
    assign mem_rd     = (st == ST_RD_EVEN) || (st == ST_RD_ODD);
    assign mem_seg    = cur_seg;
    assign mem_word   = {cur_word[WORD_W-1:1], st == ST_RD_ODD};
    assign busy       = (st != ST_IDLE) && (st != ST_FAULT);
    assign fault_code = flt_q;

    // Main sequencer: fetch, evaluate, chain, complete or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            flt_q      <= FLT_NONE;
            cur_seg    <= '0;
            cur_word   <= '0;
            cnt        <= '0;
            word0_q    <= '0;
            word1_q    <= '0;
            done       <= 1'b0;
            res_seg    <= '0;
            res_word   <= '0;
            fault      <= 1'b0;
            fault_seg  <= '0;
            fault_word <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cur_seg  <= start_seg;
                        cur_word <= start_word;
                        cnt      <= CNT_W'(1);
                        st       <= ST_RD_EVEN;
                    end
                end
                ST_RD_EVEN: st <= ST_WT_EVEN;
                ST_WT_EVEN: begin
                    if (mem_rvalid) begin
                        word0_q <= mem_rdata;
                        st      <= ST_RD_ODD;
                    end
                end
                ST_RD_ODD: st <= ST_WT_ODD;
                ST_WT_ODD: begin
                    if (mem_rvalid) begin
                        word1_q <= mem_rdata;
                        st      <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (is_trap) begin
                        fault      <= 1'b1;
                        flt_q      <= FLT_LINK;
                        fault_seg  <= ptr_seg;
                        fault_word <= ptr_word;
                        st         <= ST_FAULT;
                    end else if (!is_ptr) begin
                        fault      <= 1'b1;
                        flt_q      <= FLT_MODE;
                        fault_seg  <= cur_seg;
                        fault_word <= pair_base;
                        st         <= ST_FAULT;
                    end else if (chain && (cnt == CNT_W'(MAX_CHAIN))) begin
                        fault      <= 1'b1;
                        flt_q      <= FLT_LOOP;
                        fault_seg  <= ptr_seg;
                        fault_word <= next_word;
                        st         <= ST_FAULT;
                    end else if (chain) begin
                        cur_seg  <= ptr_seg;
                        cur_word <= next_word;
                        cnt      <= cnt + CNT_W'(1);
                        st       <= ST_RD_EVEN;
                    end else begin
                        done     <= 1'b1;
                        res_seg  <= ptr_seg;
                        res_word <= next_word;
                        st       <= ST_IDLE;
                    end
                end
                ST_FAULT: begin
                    if (fault_ack) begin
                        fault <= 1'b0;
                        flt_q <= FLT_NONE;
                        st    <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irp_resolver.sv
// Module: top of the chained pointer-pair resolver.
// Assumes a combinational index register read and a valid-qualified memory return.
module irp_resolver
    import irp_pkg::*;
#(
    parameter int SEG_W     = 14,
    parameter int WORD_W    = 18,
    parameter int NUM_IDX   = 8,
    parameter int MAX_CHAIN = 16,
    localparam int DATA_W    = SEG_W + WORD_W + MODE_W,
    localparam int IDX_SEL_W = $clog2(NUM_IDX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SEG_W-1:0]     start_seg,
    input  logic [WORD_W-1:0]    start_word,
    output logic                 busy,
    output logic                 mem_rd,
    output logic [SEG_W-1:0]     mem_seg,
    output logic [WORD_W-1:0]    mem_word,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [IDX_SEL_W-1:0] idx_sel,
    input  logic [WORD_W-1:0]    idx_val,
    output logic                 done,
    output logic [SEG_W-1:0]     res_seg,
    output logic [WORD_W-1:0]    res_word,
    output logic                 fault,
    output logic [1:0]           fault_code,
    output logic [SEG_W-1:0]     fault_seg,
    output logic [WORD_W-1:0]    fault_word,
    input  logic                 fault_ack
);
    logic [DATA_W-1:0] word0_q, word1_q;
    logic [SEG_W-1:0]  ptr_seg;
    logic [WORD_W-1:0] ptr_word, next_word;
    logic              is_ptr, is_trap, idx_en, chain;

    irp_pair_decode #(.SEG_W(SEG_W), .WORD_W(WORD_W), .IDX_SEL_W(IDX_SEL_W)) dec_i (
        .first_w  (word0_q),
        .second_w (word1_q),
        .ptr_seg  (ptr_seg),
        .ptr_word (ptr_word),
        .is_ptr   (is_ptr),
        .is_trap  (is_trap),
        .idx_en   (idx_en),
        .idx_num  (idx_sel),
        .chain    (chain)
    );

    irp_addr_calc #(.WORD_W(WORD_W)) calc_i (
        .ptr_word  (ptr_word),
        .idx_en    (idx_en),
        .idx_val   (idx_val),
        .next_word (next_word)
    );

    irp_ctrl #(.SEG_W(SEG_W), .WORD_W(WORD_W), .MAX_CHAIN(MAX_CHAIN)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_seg  (start_seg),
        .start_word (start_word),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .fault_ack  (fault_ack),
        .is_ptr     (is_ptr),
        .is_trap    (is_trap),
        .chain      (chain),
        .ptr_seg    (ptr_seg),
        .ptr_word   (ptr_word),
        .next_word  (next_word),
        .word0_q    (word0_q),
        .word1_q    (word1_q),
        .busy       (busy),
        .mem_rd     (mem_rd),
        .mem_seg    (mem_seg),
        .mem_word   (mem_word),
        .done       (done),
        .res_seg    (res_seg),
        .res_word   (res_word),
        .fault      (fault),
        .fault_code (fault_code),
        .fault_seg  (fault_seg),
        .fault_word (fault_word)
    );
endmodule

// File: rtl/irp_resolver_chk.sv
// Module: protocol checker bound to the resolver top.
// Assumes reads come in even/odd pairs and faults are held until acknowledged.
module irp_resolver_chk #(
    parameter int SEG_W     = 14,
    parameter int WORD_W    = 18,
    parameter int MAX_CHAIN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_rd,
    input logic [SEG_W-1:0]  mem_seg,
    input logic [WORD_W-1:0] mem_word,
    input logic              done,
    input logic              fault,
    input logic [1:0]        fault_code,
    input logic [SEG_W-1:0]  fault_seg,
    input logic [WORD_W-1:0] fault_word,
    input logic              fault_ack
);
    logic              odd_next;
    logic [SEG_W-1:0]  even_seg;
    logic [WORD_W-2:0] even_hi;
    int                rd_cnt;

    // Track read parity and the address of the last even read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_next <= 1'b0;
            even_seg <= '0;
            even_hi  <= '0;
        end else if (mem_rd) begin
            odd_next <= ~odd_next;
            if (!mem_word[0]) begin
                even_seg <= mem_seg;
                even_hi  <= mem_word[WORD_W-1:1];
            end
        end
    end

    // Count reads within one resolution.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) rd_cnt <= 0;
        else if (mem_rd)     rd_cnt <= rd_cnt + 1;
    end

    assert_even_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_word[0] == odd_next));
    assert_pair_same_seg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_word[0]) |-> (mem_seg == even_seg && mem_word[WORD_W-1:1] == even_hi));
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_no_done_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
    assert_chain_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= 2 * MAX_CHAIN);
    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_ack) |=> (fault && $stable(fault_code) && $stable(fault_seg) && $stable(fault_word)));
    assert_no_read_in_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_rd);
endmodule

bind irp_resolver irp_resolver_chk #(
    .SEG_W(SEG_W), .WORD_W(WORD_W), .MAX_CHAIN(MAX_CHAIN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd), .mem_seg(mem_seg),
    .mem_word(mem_word), .done(done), .fault(fault), .fault_code(fault_code),
    .fault_seg(fault_seg), .fault_word(fault_word), .fault_ack(fault_ack)
);

// File: tb/irp_resolver_tb_top.sv
`timescale 1ns/1ps
module irp_resolver_tb_top;
    localparam int SEG_W = 14, WORD_W = 18, NUM_IDX = 8, MAX_CHAIN = 16;
    localparam int DATA_W = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              start = 1'b0, fault_ack = 1'b0;
    logic [SEG_W-1:0]  start_seg = '0;
    logic [WORD_W-1:0] start_word = '0;
    logic              busy, mem_rd, done, fault;
    logic [SEG_W-1:0]  mem_seg, res_seg, fault_seg;
    logic [WORD_W-1:0] mem_word, res_word, fault_word, idx_val;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [2:0]        idx_sel;
    logic [1:0]        fault_code;

    irp_resolver #(.SEG_W(SEG_W), .WORD_W(WORD_W), .NUM_IDX(NUM_IDX), .MAX_CHAIN(MAX_CHAIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_seg(start_seg), .start_word(start_word),
        .busy(busy), .mem_rd(mem_rd), .mem_seg(mem_seg), .mem_word(mem_word),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .idx_sel(idx_sel), .idx_val(idx_val),
        .done(done), .res_seg(res_seg), .res_word(res_word), .fault(fault),
        .fault_code(fault_code), .fault_seg(fault_seg), .fault_word(fault_word),
        .fault_ack(fault_ack)
    );

    logic [DATA_W-1:0] mem [int];
    logic [WORD_W-1:0] xreg [NUM_IDX];
    int n_chk = 0, n_fail = 0, rd_total = 0;
    bit finished = 0;

    assign idx_val = xreg[idx_sel];

    function automatic int key(input logic [SEG_W-1:0] s, input logic [WORD_W-1:0] w);
        return int'({s, w});
    endfunction

    function automatic logic [DATA_W-1:0] mrd(input logic [SEG_W-1:0] s, input logic [WORD_W-1:0] w);
        if (mem.exists(key(s, w))) return mem[key(s, w)];
        return '0;
    endfunction

    function automatic logic [DATA_W-1:0] w1st(input logic [3:0] m, input logic [SEG_W-1:0] s, input logic [WORD_W-1:0] w);
        return {s, w, m};
    endfunction

    function automatic logic [DATA_W-1:0] w2nd(input bit ch, input bit xen, input logic [2:0] xn);
        return {30'd0, ch, xen, 1'b0, xn};
    endfunction

    task automatic put_pair(input logic [SEG_W-1:0] s, input logic [WORD_W-1:0] w,
                            input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
        mem[key(s, w)]     = a;
        mem[key(s, w + 1)] = b;
    endtask

    // One-cycle memory and read counter.
    always @(posedge clk) begin
        mem_rvalid <= mem_rd;
        mem_rdata  <= mrd(mem_seg, mem_word);
        if (mem_rd) rd_total <= rd_total + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural walk: kind 0 done, 1 link, 2 loop, 3 bad mode.
    task automatic model(input logic [SEG_W-1:0] s, input logic [WORD_W-1:0] w,
                         output int kind, output logic [SEG_W-1:0] es,
                         output logic [WORD_W-1:0] ew, output int np);
        logic [SEG_W-1:0]  cs = s;
        logic [WORD_W-1:0] cw = w, a, nw;
        logic [DATA_W-1:0] f, g;
        np = 0;
        forever begin
            np++;
            a = {cw[WORD_W-1:1], 1'b0};
            f = mrd(cs, a);
            g = mrd(cs, a | 1);
            if (f[3:0] == 4'hB) begin kind = 1; es = f[35:22]; ew = f[21:4]; return; end
            if (f[3:0] != 4'h3) begin kind = 3; es = cs; ew = a; return; end
            nw = f[21:4] + (g[4] ? xreg[g[2:0]] : '0);
            if (g[5]) begin
                if (np == MAX_CHAIN) begin kind = 2; es = f[35:22]; ew = nw; return; end
                cs = f[35:22];
                cw = nw;
            end else begin
                kind = 0; es = f[35:22]; ew = nw; return;
            end
        end
    endtask

    task automatic run(input logic [SEG_W-1:0] s, input logic [WORD_W-1:0] w,
                       input bit poke, input string tag);
        int kind, np, r0, rf;
        logic [SEG_W-1:0] es;
        logic [WORD_W-1:0] ew;
        bit early = 0;
        model(s, w, kind, es, ew, np);
        @(negedge clk);
        start = 1; start_seg = s; start_word = w;
        r0 = rd_total;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        for (int i = 1; i <= 5 * np; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && i == 2) begin start = 1; start_seg = 14'h3FF; start_word = 18'h777; end
            if (poke && i == 3) start = 0;
            if (i < 5 * np && (done || fault)) early = 1;
        end
        chk(!early, {tag, " R10 outcome not before 5N edges"}, early, 0);
        chk(rd_total - r0 == 2 * np, {tag, " R1 two reads per pair"}, rd_total - r0, 2 * np);
        if (kind == 0) begin
            chk(done && !fault, {tag, " R4 done strobe"}, {done, fault}, 2'b10);
            chk(res_seg == es && res_word == ew, {tag, " R2/R3 result address"}, {res_seg, res_word}, {es, ew});
            @(negedge clk);
            chk(!done, {tag, " R4 done lasts one cycle"}, done, 0);
        end else begin
            chk(fault && !done && fault_code == kind[1:0],
                {tag, kind == 1 ? " R5 link fault" : kind == 2 ? " R7 loop fault" : " R6 mode fault"},
                {done, fault, fault_code}, {2'b01, kind[1:0]});
            chk(fault_seg == es && fault_word == ew, {tag, " R5/R6/R7 fault address"},
                {fault_seg, fault_word}, {es, ew});
            rf = rd_total;
            start = 1; start_seg = 14'h1; start_word = 18'h2;
            @(negedge clk);
            start = 0;
            @(negedge clk);
            chk(fault && fault_code == kind[1:0] && fault_seg == es && fault_word == ew && rd_total == rf,
                {tag, " R8/R9 fault held, start ignored"}, {fault, fault_code, rd_total - rf}, {1'b1, kind[1:0], 32'd0});
            fault_ack = 1;
            @(negedge clk);
            fault_ack = 0;
            chk(!fault && !busy, {tag, " R8 fault cleared after ack"}, {fault, busy}, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < NUM_IDX; i++) xreg[i] = WORD_W'(i * 18'h111);
        xreg[3] = 18'h20;
        // Simple pointer, no index.
        put_pair(5, 100, w1st(4'h3, 7, 18'h1234), w2nd(0, 0, 0));
        // Indexed pointer with wrap.
        put_pair(5, 200, w1st(4'h3, 9, 18'h3FFF0), w2nd(0, 1, 3));
        // Three-pair chain.
        put_pair(2, 10, w1st(4'h3, 2, 18'd20), w2nd(1, 0, 0));
        put_pair(2, 20, w1st(4'h3, 3, 18'd30 - 18'h111), w2nd(1, 1, 1));
        put_pair(3, 30, w1st(4'h3, 11, 18'h0ABC), w2nd(0, 1, 2));
        // Unresolved link.
        put_pair(4, 40, w1st(4'hB, 1, 18'h55), w2nd(0, 0, 0));
        // Self loop.
        put_pair(8, 80, w1st(4'h3, 8, 18'd80), w2nd(1, 0, 0));
        // Chain into a link.
        put_pair(6, 90, w1st(4'h3, 4, 18'd40), w2nd(1, 0, 0));

        repeat (3) @(negedge clk);
        chk(!busy && !mem_rd && !done && !fault, "R11 reset state", {busy, mem_rd, done, fault}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_rd && !done && !fault, "R11 idle after reset", {busy, mem_rd, done, fault}, 0);

        run(5, 100, 0, "plain");
        run(5, 101, 0, "odd start");
        run(5, 200, 0, "indexed wrap");
        run(2, 10, 1, "chain3 busy-start");
        run(4, 40, 0, "link");
        put_pair(4, 40, w1st(4'h3, 1, 18'h55), w2nd(0, 0, 0));
        run(4, 40, 0, "patched link");
        run(6, 60, 0, "bad mode");
        run(8, 80, 0, "loop");
        mem[key(4, 40)] = w1st(4'hB, 12, 18'h3);
        run(6, 90, 0, "chain to link");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule